// File: doc/BRIEF.md
# Exception Context Allocator and Retirement Splicer

In a multithreaded core, a recoverable exception does not have to flush the faulting thread. This block picks a free hardware context to run the exception handler. It records which application thread owns that handler and which instruction raised the exception. It then controls per-thread retirement so that the handler's instructions are slotted into the owner's commit stream. The owner commits everything older than the excepting instruction, then the whole handler commits, then the owner resumes at the excepting instruction.

Each context is in one of three states:
- **application**: the context runs an application thread.
- **free**: the context is idle and can take a handler.
- **handler**: the context runs an exception handler.

Four events release a handler context or change it:
- A squash on the owner thread that removes the excepting instruction.
- A handler that reports it cannot finish. The block then asks for a squash of the owner from the excepting instruction, so the handler is re-run the traditional way.
- A miss to the same page found on an older instruction of the owner. This moves the splice point back to that instruction.
- A request that finds no free context. This is never stalled; it is passed to the squash-and-refetch path at once.

Sequence numbers wrap. Every age comparison treats the modular difference as signed.

Top module: `exc_thread_splicer`

## Requirements
- R1: After reset, the contexts named by parameter APP_MASK (default 4'b0011: contexts 0 and 1) are application contexts and all others are free. An application context's retire_en follows its head_valid. A free context's retire_en is 0 whatever its head_valid is.
- R2: When exc_valid is high and at least one context is free, alloc_valid is 1 in the same cycle and alloc_ctx is the lowest-numbered free context. From the next clock edge that context holds exc_tid as its owner and exc_seq as its splice point.
- R3: While a handler context's splice point equals the head_seq of its owner, the owner's retire_en is 0 and the handler context's retire_en equals its own head_valid. Otherwise the handler context's retire_en is 0.
- R4: rfe_valid with rfe_ctx naming a handler context whose splice is active returns that context to free at the next edge. The owner's retirement is then re-enabled.
- R5: sq_valid with thread sq_tid and boundary sq_seq frees every handler context owned by sq_tid whose splice point is at or younger than sq_seq. Handler contexts of other threads, or with an older splice point, are unaffected.
- R6: When exc_valid is high and no context is free, fallback is 1 and alloc_valid is 0. No state changes.
- R7: relink_valid on a handler context replaces its splice point with relink_seq only when relink_seq is older than the stored value. A younger relink_seq is ignored.
- R8: hard_valid on a handler context drives hard_sq_valid=1 in the same cycle, with hard_sq_tid and hard_sq_seq set to that context's owner and splice point. The context becomes free at the next edge.
- R9: Age comparisons are modulo 2^SEQ_W. Value a is older than b when bit SEQ_W-1 of (a-b) is 1. With SEQ_W=6, 62 is older than 1.
- R10: For one exception, an owner's committed stream is its pre-exception instructions, then every handler instruction, then the excepting and later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request |
| exc_tid | input | CTX_W | Faulting thread |
| exc_seq | input | SEQ_W | Sequence number of the excepting instruction |
| head_valid | input | NUM_CTX | Per-context oldest instruction is ready to commit |
| head_seq | input | NUM_CTX*SEQ_W | Per-context sequence number of the oldest uncommitted instruction (context i at bits i*SEQ_W upward) |
| sq_valid | input | 1 | Squash event |
| sq_tid | input | CTX_W | Squashed thread |
| sq_seq | input | SEQ_W | Oldest squashed sequence number |
| rfe_valid | input | 1 | Return-from-exception commits this cycle |
| rfe_ctx | input | CTX_W | Context committing the return |
| relink_valid | input | 1 | Same-page miss found on an older instruction |
| relink_ctx | input | CTX_W | Handler context to re-link |
| relink_seq | input | SEQ_W | Sequence number of the older instruction |
| hard_valid | input | 1 | Handler asks for full traditional handling |
| hard_ctx | input | CTX_W | Handler context raising it |
| alloc_valid | output | 1 | A context was granted |
| alloc_ctx | output | CTX_W | Granted context |
| fallback | output | 1 | Use squash-and-refetch for this request |
| retire_en | output | NUM_CTX | Per-context commit permission |
| hard_sq_valid | output | 1 | Squash request for re-execution |
| hard_sq_tid | output | CTX_W | Thread to squash |
| hard_sq_seq | output | SEQ_W | First sequence number to squash |

## Verification
The assertions assume the following about the environment:
- exc_tid always names an application context.
- rfe_valid is raised only in a cycle where that context is allowed to commit.
- The live sequence numbers of one thread span less than half the sequence space, so the signed-difference age test is meaningful.

The directed stimulus respects these limits:
- Exceptions are raised only on contexts 0 and 1.
- The return is driven only on the last handler instruction, in the cycle the bench sees that instruction commit.
- All sequence values stay within a 32-entry window, including the case that crosses the wrap point.

// File: rtl/exc_splice_pkg.sv
package exc_splice_pkg;

  typedef enum logic [1:0] {
    CTX_APP  = 2'd0,
    CTX_FREE = 2'd1,
    CTX_HNDL = 2'd2
  } ctx_state_e;

  // a older than b in a modulo 2^w sequence space
  function automatic logic seq_is_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // a at or younger than b
  function automatic logic seq_at_or_after(input logic [31:0] a, input logic [31:0] b, input int w);
    return !seq_is_older(a, b, w);
  endfunction

endpackage

// File: rtl/exc_ctx_alloc.sv
module exc_ctx_alloc #(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX-1:0] free_vec,
  input  logic               req,
  output logic               grant_valid,
  output logic [CTX_W-1:0]   grant_idx,
  output logic [NUM_CTX-1:0] grant_oh,
  output logic               none_free
);
  logic [NUM_CTX-1:0] lowest;

  // isolate lowest set bit
  assign lowest    = free_vec & (~free_vec + 1'b1);
  assign none_free = (free_vec == '0);
  assign grant_valid = req && !none_free;
  assign grant_oh  = grant_valid ? lowest : '0;

  always_comb begin
    grant_idx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (free_vec[i]) grant_idx = i[CTX_W-1:0];
    end
  end
endmodule

// File: rtl/exc_ctx_slot.sv
module exc_ctx_slot
  import exc_splice_pkg::*;
#(
  parameter int SEQ_W = 6,
  parameter int CTX_W = 2,
  parameter bit START_APP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  logic [CTX_W-1:0] alloc_tid,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             sq_valid,
  input  logic [CTX_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             rfe_hit,
  input  logic             hard_hit,
  input  logic             relink_hit,
  input  logic [SEQ_W-1:0] relink_seq,
  output ctx_state_e       state_q,
  output logic [CTX_W-1:0] owner_q,
  output logic [SEQ_W-1:0] spl_seq_q,
  output logic             release_ev
);
  logic is_hndl, squash_hit, relink_take;

  assign is_hndl    = (state_q == CTX_HNDL);
  assign squash_hit = is_hndl && sq_valid && (sq_tid == owner_q) &&
                      seq_at_or_after(32'(spl_seq_q), 32'(sq_seq), SEQ_W);
  assign release_ev = squash_hit || (is_hndl && (rfe_hit || hard_hit));
  assign relink_take = is_hndl && relink_hit &&
                       seq_is_older(32'(relink_seq), 32'(spl_seq_q), SEQ_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= START_APP ? CTX_APP : CTX_FREE;
      owner_q   <= '0;
      spl_seq_q <= '0;
    end else if (release_ev) begin
      state_q <= CTX_FREE;
    end else if (alloc_hit && state_q == CTX_FREE) begin
      state_q   <= CTX_HNDL;
      owner_q   <= alloc_tid;
      spl_seq_q <= alloc_seq;
    end else if (relink_take) begin
      spl_seq_q <= relink_seq;
    end
  end
endmodule

// File: rtl/exc_retire_gate.sv
module exc_retire_gate #(
  parameter int NUM_CTX = 4,
  parameter int SEQ_W = 6,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX-1:0]            is_app,
  input  logic [NUM_CTX-1:0]            is_hndl,
  input  logic [NUM_CTX-1:0][CTX_W-1:0] owner,
  input  logic [NUM_CTX-1:0][SEQ_W-1:0] spl_seq,
  input  logic [NUM_CTX-1:0]            head_valid,
  input  logic [NUM_CTX-1:0][SEQ_W-1:0] head_seq,
  output logic [NUM_CTX-1:0]            splice_on,
  output logic [NUM_CTX-1:0]            owner_frozen,
  output logic [NUM_CTX-1:0]            retire_en
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_splice
    assign splice_on[c] = is_hndl[c] && (head_seq[owner[c]] == spl_seq[c]);
  end

  always_comb begin
    owner_frozen = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (splice_on[c]) owner_frozen[owner[c]] = 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_CTX; t++) begin : g_ret
    assign retire_en[t] = head_valid[t] &&
                          ((is_app[t] && !owner_frozen[t]) || splice_on[t]);
  end
endmodule

// File: rtl/exc_thread_splicer.sv
module exc_thread_splicer
  import exc_splice_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int SEQ_W = 6,
  parameter logic [NUM_CTX-1:0] APP_MASK = 4'b0011,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exc_valid,
  input  logic [CTX_W-1:0]         exc_tid,
  input  logic [SEQ_W-1:0]         exc_seq,
  input  logic [NUM_CTX-1:0]       head_valid,
  input  logic [NUM_CTX*SEQ_W-1:0] head_seq,
  input  logic                     sq_valid,
  input  logic [CTX_W-1:0]         sq_tid,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic                     rfe_valid,
  input  logic [CTX_W-1:0]         rfe_ctx,
  input  logic                     relink_valid,
  input  logic [CTX_W-1:0]         relink_ctx,
  input  logic [SEQ_W-1:0]         relink_seq,
  input  logic                     hard_valid,
  input  logic [CTX_W-1:0]         hard_ctx,
  output logic                     alloc_valid,
  output logic [CTX_W-1:0]         alloc_ctx,
  output logic                     fallback,
  output logic [NUM_CTX-1:0]       retire_en,
  output logic                     hard_sq_valid,
  output logic [CTX_W-1:0]         hard_sq_tid,
  output logic [SEQ_W-1:0]         hard_sq_seq
);
  logic [NUM_CTX-1:0]            is_app, is_free, is_hndl;
  logic [NUM_CTX-1:0][CTX_W-1:0] owner;
  logic [NUM_CTX-1:0][SEQ_W-1:0] spl_seq, head_arr;
  logic [NUM_CTX-1:0]            grant_oh, splice_on, owner_frozen, release_ev;
  logic                          none_free;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_head
    assign head_arr[i] = head_seq[i*SEQ_W +: SEQ_W];
  end

  exc_ctx_alloc #(.NUM_CTX(NUM_CTX)) u_alloc (
    .free_vec   (is_free),
    .req        (exc_valid),
    .grant_valid(alloc_valid),
    .grant_idx  (alloc_ctx),
    .grant_oh   (grant_oh),
    .none_free  (none_free)
  );

  assign fallback = exc_valid && none_free;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    ctx_state_e st;
    logic rfe_hit, hard_hit, relink_hit;

    assign rfe_hit    = rfe_valid && (rfe_ctx == CTX_W'(c)) && splice_on[c];
    assign hard_hit   = hard_valid && (hard_ctx == CTX_W'(c));
    assign relink_hit = relink_valid && (relink_ctx == CTX_W'(c));

    exc_ctx_slot #(.SEQ_W(SEQ_W), .CTX_W(CTX_W), .START_APP(APP_MASK[c])) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_hit (grant_oh[c]),
      .alloc_tid (exc_tid),
      .alloc_seq (exc_seq),
      .sq_valid  (sq_valid),
      .sq_tid    (sq_tid),
      .sq_seq    (sq_seq),
      .rfe_hit   (rfe_hit),
      .hard_hit  (hard_hit),
      .relink_hit(relink_hit),
      .relink_seq(relink_seq),
      .state_q   (st),
      .owner_q   (owner[c]),
      .spl_seq_q (spl_seq[c]),
      .release_ev(release_ev[c])
    );

    assign is_app[c]  = (st == CTX_APP);
    assign is_free[c] = (st == CTX_FREE);
    assign is_hndl[c] = (st == CTX_HNDL);
  end

  exc_retire_gate #(.NUM_CTX(NUM_CTX), .SEQ_W(SEQ_W)) u_gate (
    .is_app      (is_app),
    .is_hndl     (is_hndl),
    .owner       (owner),
    .spl_seq     (spl_seq),
    .head_valid  (head_valid),
    .head_seq    (head_arr),
    .splice_on   (splice_on),
    .owner_frozen(owner_frozen),
    .retire_en   (retire_en)
  );

  assign hard_sq_valid = hard_valid && is_hndl[hard_ctx];
  assign hard_sq_tid   = owner[hard_ctx];
  assign hard_sq_seq   = spl_seq[hard_ctx];
endmodule

// File: rtl/exc_thread_splicer_chk.sv
module exc_thread_splicer_chk #(
  parameter int NUM_CTX = 4,
  parameter int SEQ_W = 6,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            exc_valid,
  input logic                            alloc_valid,
  input logic [CTX_W-1:0]                alloc_ctx,
  input logic                            fallback,
  input logic [NUM_CTX-1:0]              retire_en,
  input logic                            rfe_valid,
  input logic [CTX_W-1:0]                rfe_ctx,
  input logic                            hard_sq_valid,
  input logic [CTX_W-1:0]                hard_ctx,
  input logic                            relink_valid,
  input logic [NUM_CTX-1:0]              is_hndl,
  input logic [NUM_CTX-1:0]              is_free,
  input logic [NUM_CTX-1:0][CTX_W-1:0]   owner,
  input logic [NUM_CTX-1:0][SEQ_W-1:0]   spl_seq
);
  a_r2_grant_takes: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> is_hndl[$past(alloc_ctx)]);

  a_r6_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (alloc_valid != fallback));

  a_r4_return_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_valid && is_hndl[rfe_ctx] && retire_en[rfe_ctx]) |=> is_free[$past(rfe_ctx)]);

  a_r8_hard_frees: assert property (@(posedge clk) disable iff (!rst_n)
    hard_sq_valid |=> is_free[$past(hard_ctx)]);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      is_hndl[c] |-> !(retire_en[c] && retire_en[owner[c]]));

    a_r1_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      is_free[c] |-> !retire_en[c]);

    a_r7_point_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (is_hndl[c] && !relink_valid) |=> (!is_hndl[c] || $stable(spl_seq[c])));
  end
endmodule

bind exc_thread_splicer exc_thread_splicer_chk #(.NUM_CTX(NUM_CTX), .SEQ_W(SEQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_valid    (exc_valid),
  .alloc_valid  (alloc_valid),
  .alloc_ctx    (alloc_ctx),
  .fallback     (fallback),
  .retire_en    (retire_en),
  .rfe_valid    (rfe_valid),
  .rfe_ctx      (rfe_ctx),
  .hard_sq_valid(hard_sq_valid),
  .hard_ctx     (hard_ctx),
  .relink_valid (relink_valid),
  .is_hndl      (is_hndl),
  .is_free      (is_free),
  .owner        (owner),
  .spl_seq      (spl_seq)
);

// File: tb/exc_thread_splicer_bench.sv
module exc_thread_splicer_bench;
  localparam int N = 4;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 0, sq_valid = 0, rfe_valid = 0, relink_valid = 0, hard_valid = 0;
  logic [1:0] exc_tid = 0, sq_tid = 0, rfe_ctx = 0, relink_ctx = 0, hard_ctx = 0;
  logic [SW-1:0] exc_seq = 0, sq_seq = 0, relink_seq = 0;
  logic [N-1:0] hv = '1;
  logic [N-1:0][SW-1:0] hs = '0;
  logic alloc_valid, fallback, hard_sq_valid;
  logic [1:0] alloc_ctx, hard_sq_tid;
  logic [SW-1:0] hard_sq_seq;
  logic [N-1:0] retire_en;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_thread_splicer u_exc_thread_splicer (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_tid(exc_tid), .exc_seq(exc_seq),
    .head_valid(hv), .head_seq(hs),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .rfe_valid(rfe_valid), .rfe_ctx(rfe_ctx),
    .relink_valid(relink_valid), .relink_ctx(relink_ctx), .relink_seq(relink_seq),
    .hard_valid(hard_valid), .hard_ctx(hard_ctx),
    .alloc_valid(alloc_valid), .alloc_ctx(alloc_ctx), .fallback(fallback),
    .retire_en(retire_en),
    .hard_sq_valid(hard_sq_valid), .hard_sq_tid(hard_sq_tid), .hard_sq_seq(hard_sq_seq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic raise_exc(input int tid, input int seq);
    exc_valid = 1; exc_tid = 2'(tid); exc_seq = SW'(seq);
  endtask

  task automatic squash(input int tid, input int seq);
    sq_valid = 1; sq_tid = 2'(tid); sq_seq = SW'(seq);
    next_cycle();
    sq_valid = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 retire_en after reset", int'(retire_en), 3);
    chk("R1 no grant at rest", int'(alloc_valid), 0);
    chk("R1 no fallback at rest", int'(fallback), 0);
    next_cycle();
  endtask

  task automatic t_splice();
    int exp_s[9] = '{7, 8, 9, 100, 101, 102, 10, 11, 12};
    int got[$];
    int h0 = 7;
    int hl = 3;
    hs[0] = 6'd7;
    raise_exc(0, 10);
    #1;
    chk("R2 grant valid", int'(alloc_valid), 1);
    chk("R2 lowest free context", int'(alloc_ctx), 2);
    chk("R2 no fallback", int'(fallback), 0);
    next_cycle();
    exc_valid = 0;
    for (int cyc = 0; cyc < 9; cyc++) begin
      hs[0] = SW'(h0);
      rfe_valid = (hl == 1);
      rfe_ctx = 2'd2;
      #1;
      if (h0 == 10 && hl > 0) chk("R3 owner frozen at splice point", int'(retire_en[0]), 0);
      if (retire_en[2] && hl > 0) begin got.push_back(100 + 3 - hl); hl--; end
      if (retire_en[0]) begin got.push_back(h0); h0++; end
      next_cycle();
    end
    rfe_valid = 0;
    #1;
    chk("R4 handler context released", int'(retire_en[2]), 0);
    chk("R10 stream length", got.size(), 9);
    for (int i = 0; i < 9; i++) chk("R10 stream order", (i < got.size()) ? got[i] : -1, exp_s[i]);
    next_cycle();
  endtask

  task automatic t_fallback_squash();
    hs[0] = 0; hs[1] = 0;
    raise_exc(0, 20);
    #1; chk("R2 first grant", int'(alloc_ctx), 2);
    next_cycle();
    raise_exc(1, 5);
    #1; chk("R2 second grant", int'(alloc_ctx), 3);
    next_cycle();
    raise_exc(0, 30);
    #1;
    chk("R6 fallback when full", int'(fallback), 1);
    chk("R6 no grant when full", int'(alloc_valid), 0);
    next_cycle();
    exc_valid = 0;
    hs[1] = 6'd5;
    #1;
    chk("R3 owner 1 frozen", int'(retire_en[1]), 0);
    chk("R3 handler 3 enabled", int'(retire_en[3]), 1);
    squash(1, 6);
    #1; chk("R5 younger boundary keeps handler", int'(retire_en[1]), 0);
    squash(1, 5);
    #1;
    chk("R5 boundary at splice point frees", int'(retire_en[1]), 1);
    chk("R5 freed handler quiet", int'(retire_en[3]), 0);
    hs[0] = 6'd20;
    squash(1, 0);
    #1; chk("R5 other thread squash ignored", int'(retire_en[0]), 0);
    squash(0, 18);
    #1;
    chk("R5 older boundary frees", int'(retire_en[0]), 1);
    chk("R5 handler 2 quiet", int'(retire_en[2]), 0);
    next_cycle();
  endtask

  task automatic t_relink_hard();
    hs[0] = 0;
    raise_exc(0, 40);
    #1; chk("R2 grant after frees", int'(alloc_ctx), 2);
    next_cycle();
    exc_valid = 0;
    relink_valid = 1; relink_ctx = 2; relink_seq = 6'd45;
    next_cycle();
    relink_valid = 0; hs[0] = 6'd40;
    #1; chk("R7 younger relink ignored", int'(retire_en[0]), 0);
    relink_valid = 1; relink_seq = 6'd38;
    next_cycle();
    relink_valid = 0; hs[0] = 6'd38;
    #1;
    chk("R7 frozen at older point", int'(retire_en[0]), 0);
    chk("R7 handler enabled at older point", int'(retire_en[2]), 1);
    hs[0] = 6'd40;
    #1; chk("R7 old point released", int'(retire_en[0]), 1);
    hs[0] = 6'd38;
    hard_valid = 1; hard_ctx = 2;
    #1;
    chk("R8 squash request", int'(hard_sq_valid), 1);
    chk("R8 squash thread", int'(hard_sq_tid), 0);
    chk("R8 squash point", int'(hard_sq_seq), 38);
    next_cycle();
    hard_valid = 0;
    #1;
    chk("R8 handler discarded", int'(retire_en[2]), 0);
    chk("R8 owner resumes", int'(retire_en[0]), 1);
    next_cycle();
  endtask

  task automatic t_wrap();
    hs[1] = 6'd62;
    raise_exc(1, 62);
    #1; chk("R9 grant", int'(alloc_ctx), 2);
    next_cycle();
    exc_valid = 0;
    squash(1, 1);
    #1; chk("R9 wrapped boundary is younger", int'(retire_en[1]), 0);
    squash(1, 61);
    #1; chk("R9 older boundary frees", int'(retire_en[1]), 1);
    next_cycle();
  endtask

  initial begin
    repeat (3) next_cycle();
    rst_n = 1;
    t_reset();
    t_splice();
    t_fallback_squash();
    t_relink_hard();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule